// File: doc/BRIEF.md
# Exponential Backoff Lock Requester

This block obtains a single-bit lock word in shared memory on behalf of one client. It probes the word with an atomic test-and-set sent to an external atomic memory port. The word reads 0 when the lock is open and 1 when it is closed. If the old value returned is 0, the probe has just closed the lock for this client and the block reports ownership. If the old value is 1, another agent owns the lock. The block then stays silent for a pause before it probes again, and each failed probe doubles the pause up to a ceiling. This keeps memory traffic low while the lock is held elsewhere.

The client pulses `acquire_i` while the block is idle and then waits for `granted_o`. When it has finished with the shared data, the client pulses `release_i`. The block then issues a store-zero to the lock word and returns to idle. The controller has six states:

- IDLE: waiting for a request.
- PROBE: presenting a test-and-set.
- WAIT_RESP: waiting for the old value.
- BACKOFF: counting out the pause.
- HELD: the lock is owned.
- RELEASE: presenting the store-zero.

The transitions are:

- IDLE→PROBE on acquire.
- PROBE→WAIT_RESP when the request is accepted.
- WAIT_RESP→HELD on an old value of 0.
- WAIT_RESP→BACKOFF on an old value of 1.
- BACKOFF→PROBE when the pause expires.
- HELD→RELEASE on release.
- RELEASE→IDLE when the store is accepted.

Top module: `backoff_lock_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `granted_o` and `mem_req_o` are low.
- R2: An `acquire_i` sampled high while idle raises `mem_req_o` in the next cycle, with `mem_op_o` = 0, which encodes test-and-set.
- R3: A request stays high with `mem_op_o` unchanged until it is accepted, that is, until `mem_ready_i` is high at a clock edge. After a test-and-set has been accepted, no new request is made until its response arrives.
- R4: A response (`mem_rsp_valid_i` high) whose old value is 0 (lock was open) makes `granted_o` high from the next cycle. `granted_o` stays high until a release is taken.
- R5: A response whose old value is 1 (lock closed) is followed by exactly D cycles with no request before the next test-and-set. The first D of an acquisition equals INIT_DELAY.
- R6: Each further failed probe within the same acquisition doubles D, saturating at MAX_DELAY.
- R7: When the lock is obtained, D returns to INIT_DELAY for the next acquisition.
- R8: A `release_i` sampled while `granted_o` is high drops `granted_o` and raises `mem_req_o` with `mem_op_o` = 1 (store zero) in the next cycle. Once that store is accepted, the block is idle with no request.
- R9: `release_i` has no effect outside the held state. It never causes a store-zero, and it does not change the timing of a pending pause.
- R10: While `granted_o` is high, no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acquire_i | input | 1 | Start an acquisition (sampled in idle) |
| release_i | input | 1 | Give the lock back (sampled while held) |
| granted_o | output | 1 | Lock is owned by this client |
| mem_req_o | output | 1 | Atomic memory request valid |
| mem_op_o | output | 1 | 0 = test-and-set, 1 = store zero |
| mem_ready_i | input | 1 | Memory accepts the request at this edge |
| mem_rsp_valid_i | input | 1 | Test-and-set response valid |
| mem_rsp_old_i | input | 1 | Old lock value returned by the test-and-set |

## Verification
- **Acquire:** The test-and-set request appears one cycle after an accepted acquire.
- **Response:** Ownership shows one cycle after a response carrying 0.
- **Release:** The store-zero request and the drop of `granted_o` both appear one cycle after a release sampled in the held state.
- **Failed probe:** The next request after a response carrying 1 appears after exactly D + 1 cycles. The bench drives every input at a falling edge and samples at the next falling edge. It counts falling edges from the response it drove until the request is seen, and compares that count with D + 1, where D comes from a bench function that doubles and saturates independently.
- **Stimulus:** Random ready stalls, random response latency and random failure counts per round vary when each result falls due. Every check therefore waits on the handshake it depends on, not on a fixed schedule.

// File: rtl/lock_engine_pkg.sv
package lock_engine_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROBE     = 3'd1,
        ST_WAIT_RESP = 3'd2,
        ST_BACKOFF   = 3'd3,
        ST_HELD      = 3'd4,
        ST_RELEASE   = 3'd5
    } lock_state_e;

    typedef enum logic {
        OP_TEST_SET   = 1'b0,
        OP_STORE_ZERO = 1'b1
    } mem_op_e;

endpackage

// File: rtl/backoff_timer.sv
module backoff_timer #(
    parameter int INIT_DELAY = 1,
    parameter int MAX_DELAY  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic restart_i,
    input  logic run_i,
    output logic done_o
);
    localparam int DW = $clog2(MAX_DELAY + 1);
    localparam logic [DW-1:0] INIT_V = DW'(INIT_DELAY);
    localparam logic [DW-1:0] MAX_V  = DW'(MAX_DELAY);

    if (INIT_DELAY < 1 || MAX_DELAY < INIT_DELAY) begin : g_bad_limits
        $error("backoff_timer: need 1 <= INIT_DELAY <= MAX_DELAY");
    end

    logic [DW-1:0] delay_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] next_delay;
    logic [DW:0]   doubled;

    assign doubled = {delay_q, 1'b0};

    always_comb begin
        if (doubled > {1'b0, MAX_V}) begin
            next_delay = MAX_V;
        end else begin
            next_delay = doubled[DW-1:0];
        end
    end

    // Pause length for the next failure; doubles per failure, restarts on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q <= INIT_V;
        end else if (restart_i) begin
            delay_q <= INIT_V;
        end else if (load_i) begin
            delay_q <= next_delay;
        end
    end

    // Countdown of the pause currently running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= delay_q;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == DW'(1));

endmodule

// File: rtl/tas_port.sv
module tas_port
    import lock_engine_pkg::*;
(
    input  mem_op_e req_op_i,
    input  logic    req_issue_i,
    input  logic    rsp_expect_i,
    input  logic    mem_ready_i,
    input  logic    mem_rsp_valid_i,
    input  logic    mem_rsp_old_i,
    output logic    mem_req_o,
    output logic    mem_op_o,
    output logic    req_accept_o,
    output logic    rsp_success_o,
    output logic    rsp_fail_o
);
    assign mem_req_o    = req_issue_i;
    assign mem_op_o     = req_op_i;
    assign req_accept_o = req_issue_i & mem_ready_i;

    // A response only counts while one is outstanding.
    assign rsp_success_o = rsp_expect_i & mem_rsp_valid_i & ~mem_rsp_old_i;
    assign rsp_fail_o    = rsp_expect_i & mem_rsp_valid_i &  mem_rsp_old_i;

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_engine_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    acquire_i,
    input  logic    release_i,
    input  logic    req_accept_i,
    input  logic    rsp_success_i,
    input  logic    rsp_fail_i,
    input  logic    backoff_done_i,
    output logic    granted_o,
    output logic    req_issue_o,
    output mem_op_e req_op_o,
    output logic    rsp_expect_o,
    output logic    backoff_load_o,
    output logic    backoff_run_o,
    output logic    delay_restart_o
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (acquire_i)      state_d = ST_PROBE;
            ST_PROBE:     if (req_accept_i)   state_d = ST_WAIT_RESP;
            ST_WAIT_RESP: begin
                if (rsp_success_i)      state_d = ST_HELD;
                else if (rsp_fail_i)    state_d = ST_BACKOFF;
            end
            ST_BACKOFF:   if (backoff_done_i) state_d = ST_PROBE;
            ST_HELD:      if (release_i)      state_d = ST_RELEASE;
            ST_RELEASE:   if (req_accept_i)   state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        granted_o       = 1'b0;
        req_issue_o     = 1'b0;
        req_op_o        = OP_TEST_SET;
        rsp_expect_o    = 1'b0;
        backoff_load_o  = 1'b0;
        backoff_run_o   = 1'b0;
        delay_restart_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PROBE: begin
                req_issue_o = 1'b1;
                req_op_o    = OP_TEST_SET;
            end
            ST_WAIT_RESP: begin
                rsp_expect_o    = 1'b1;
                backoff_load_o  = rsp_fail_i;
                delay_restart_o = rsp_success_i;
            end
            ST_BACKOFF: backoff_run_o = 1'b1;
            ST_HELD:    granted_o     = 1'b1;
            ST_RELEASE: begin
                req_issue_o = 1'b1;
                req_op_o    = OP_STORE_ZERO;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/backoff_lock_engine.sv
module backoff_lock_engine
    import lock_engine_pkg::*;
#(
    parameter int INIT_DELAY = 1,
    parameter int MAX_DELAY  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acquire_i,
    input  logic release_i,
    output logic granted_o,
    output logic mem_req_o,
    output logic mem_op_o,
    input  logic mem_ready_i,
    input  logic mem_rsp_valid_i,
    input  logic mem_rsp_old_i
);
    mem_op_e req_op;
    logic    req_issue;
    logic    rsp_expect;
    logic    req_accept;
    logic    rsp_success;
    logic    rsp_fail;
    logic    backoff_load;
    logic    backoff_run;
    logic    backoff_done;
    logic    delay_restart;

    lock_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .acquire_i       (acquire_i),
        .release_i       (release_i),
        .req_accept_i    (req_accept),
        .rsp_success_i   (rsp_success),
        .rsp_fail_i      (rsp_fail),
        .backoff_done_i  (backoff_done),
        .granted_o       (granted_o),
        .req_issue_o     (req_issue),
        .req_op_o        (req_op),
        .rsp_expect_o    (rsp_expect),
        .backoff_load_o  (backoff_load),
        .backoff_run_o   (backoff_run),
        .delay_restart_o (delay_restart)
    );

    tas_port u_port (
        .req_op_i        (req_op),
        .req_issue_i     (req_issue),
        .rsp_expect_i    (rsp_expect),
        .mem_ready_i     (mem_ready_i),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_old_i   (mem_rsp_old_i),
        .mem_req_o       (mem_req_o),
        .mem_op_o        (mem_op_o),
        .req_accept_o    (req_accept),
        .rsp_success_o   (rsp_success),
        .rsp_fail_o      (rsp_fail)
    );

    backoff_timer #(
        .INIT_DELAY (INIT_DELAY),
        .MAX_DELAY  (MAX_DELAY)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (backoff_load),
        .restart_i (delay_restart),
        .run_i     (backoff_run),
        .done_o    (backoff_done)
    );

endmodule

// File: rtl/backoff_lock_engine_sva.sv
module lock_engine_checker #(
    parameter int MAX_DELAY = 64
) (
    input logic clk,
    input logic rst_n,
    input logic acquire_i,
    input logic release_i,
    input logic granted_o,
    input logic mem_req_o,
    input logic mem_op_o,
    input logic mem_ready_i,
    input logic mem_rsp_valid_i,
    input logic mem_rsp_old_i
);
    logic        outst_q;
    logic        in_pause_q;
    logic [31:0] pause_cnt_q;
    logic        unused_acq;

    assign unused_acq = acquire_i;

    // Tracks a test-and-set that has been accepted and not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_req_o && mem_ready_i && !mem_op_o) begin
            outst_q <= 1'b1;
        end else if (mem_rsp_valid_i) begin
            outst_q <= 1'b0;
        end
    end

    // Measures the silent window after a failed probe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pause_q  <= 1'b0;
            pause_cnt_q <= '0;
        end else if (outst_q && mem_rsp_valid_i && mem_rsp_old_i) begin
            in_pause_q  <= 1'b1;
            pause_cnt_q <= '0;
        end else if (in_pause_q && mem_req_o) begin
            in_pause_q  <= 1'b0;
        end else if (in_pause_q) begin
            pause_cnt_q <= pause_cnt_q + 32'd1;
        end
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_op_o));

    assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_req_o);

    assert_grant_on_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q && mem_rsp_valid_i && !mem_rsp_old_i |=> granted_o);

    assert_grant_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted_o) |-> $past(outst_q && mem_rsp_valid_i && !mem_rsp_old_i));

    assert_pause_on_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q && mem_rsp_valid_i && mem_rsp_old_i |=> !mem_req_o && !granted_o);

    assert_pause_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_pause_q |-> pause_cnt_q <= 32'(MAX_DELAY));

    assert_release_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        granted_o && release_i |=> !granted_o && mem_req_o && mem_op_o);

    assert_no_stray_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !granted_o && !(mem_req_o && mem_op_o) |=> !(mem_req_o && mem_op_o));

    assert_held_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        granted_o |-> !mem_req_o);

endmodule

bind backoff_lock_engine lock_engine_checker #(.MAX_DELAY(MAX_DELAY)) u_chk (.*);

// File: tb/backoff_lock_engine_tb.sv
module backoff_lock_engine_tb;
    localparam int TB_INIT = 1;
    localparam int TB_MAX  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acquire = 1'b0;
    logic rel = 1'b0;
    logic mem_ready = 1'b0;
    logic rsp_valid = 1'b0;
    logic rsp_old = 1'b0;
    logic granted, mem_req, mem_op;

    bit lock_word;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    backoff_lock_engine #(.INIT_DELAY(TB_INIT), .MAX_DELAY(TB_MAX)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .acquire_i       (acquire),
        .release_i       (rel),
        .granted_o       (granted),
        .mem_req_o       (mem_req),
        .mem_op_o        (mem_op),
        .mem_ready_i     (mem_ready),
        .mem_rsp_valid_i (rsp_valid),
        .mem_rsp_old_i   (rsp_old)
    );

    function automatic int exp_delay(input int k);
        int d = TB_INIT;
        for (int i = 0; i < k; i++) d = (2 * d > TB_MAX) ? TB_MAX : 2 * d;
        return d;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Requester is presenting a test-and-set now; serve it, answer it.
    // Returns at the falling edge after the response edge.
    task automatic serve_probe(output bit old_val);
        int stall = $urandom % 3;
        int lat = $urandom % 3;
        for (int s = 0; s < stall; s++) begin
            tick();
            check(mem_req && !mem_op, "R3 hold", {mem_req, mem_op}, 2);
        end
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        old_val = lock_word;
        lock_word = 1'b1;
        check(!mem_req, "R3 one outstanding", mem_req, 0);
        for (int l = 0; l < lat; l++) begin
            tick();
            check(!mem_req && !granted, "R3 wait", {mem_req, granted}, 0);
        end
        rsp_valid = 1'b1;
        rsp_old = old_val;
        tick();
        rsp_valid = 1'b0;
        rsp_old = 1'b0;
    endtask

    task automatic acquire_round(input int n_fail, input bit first_round, input bit poke_rel);
        bit old_val;
        int gap;
        lock_word = 1'b1;
        acquire = 1'b1;
        tick();
        acquire = 1'b0;
        check(mem_req && !mem_op, "R2", {mem_req, mem_op}, 2);
        for (int k = 0; k <= n_fail; k++) begin
            if (k == n_fail) lock_word = 1'b0;
            serve_probe(old_val);
            if (old_val == 1'b0) begin
                check(granted && !mem_req, "R4", {granted, mem_req}, 2);
            end else begin
                gap = 1;
                if (poke_rel) rel = 1'b1;
                while (!mem_req && gap < 200) begin
                    tick();
                    rel = 1'b0;
                    gap++;
                end
                rel = 1'b0;
                if (k == 0 && !first_round)
                    check(gap == exp_delay(0) + 1, "R7", gap, exp_delay(0) + 1);
                else if (k == 0)
                    check(gap == exp_delay(0) + 1, "R5", gap, exp_delay(0) + 1);
                else if (poke_rel)
                    check(gap == exp_delay(k) + 1, "R9 pause", gap, exp_delay(k) + 1);
                else
                    check(gap == exp_delay(k) + 1, "R6", gap, exp_delay(k) + 1);
                check(mem_req && !mem_op, "R5 probe op", {mem_req, mem_op}, 2);
            end
        end
        // Hold for a while; nothing on the memory port.
        for (int h = 0; h < 2 + int'($urandom % 4); h++) begin
            tick();
            check(granted && !mem_req, "R10", {granted, mem_req}, 2);
        end
        rel = 1'b1;
        tick();
        rel = 1'b0;
        check(!granted && mem_req && mem_op, "R8 store", {granted, mem_req, mem_op}, 3);
        for (int s = 0; s < int'($urandom % 3); s++) begin
            tick();
            check(mem_req && mem_op, "R3 store hold", {mem_req, mem_op}, 3);
        end
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        lock_word = 1'b0;
        for (int i = 0; i < 2; i++) begin
            check(!mem_req && !granted, "R8 idle", {mem_req, granted}, 0);
            tick();
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick();
        tick();
        check(!granted && !mem_req, "R1 in reset", {granted, mem_req}, 0);
        rst_n = 1'b1;
        tick();
        check(!granted && !mem_req, "R1 after reset", {granted, mem_req}, 0);

        // Release while idle must do nothing.
        rel = 1'b1;
        tick();
        rel = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!granted && !mem_req, "R9 idle", {granted, mem_req}, 0);
            tick();
        end

        acquire_round(0, 1'b1, 1'b0);  // free lock on first probe
        acquire_round(7, 1'b0, 1'b0);  // runs into saturation
        acquire_round(3, 1'b0, 1'b1);  // release pokes during pauses
        for (int r = 0; r < 8; r++) acquire_round(int'($urandom % 8), 1'b0, r[0]);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule